// File: doc/BRIEF.md
# Pin Drive Formatter

This block holds the drive state of one tester pin. It is made of two set/reset state elements: the drive data level and the drive enable. Up to four timed event strobes arrive each clock from the pin's own delay generators, and each strobe carries a 4-bit event code. The block decodes every code into set and clear actions on the two elements and applies them in event-index order within the cycle. The enabled driver and the termination load are mutually exclusive, so the load-enable output is always the complement of the drive enable.

When pair mode is asserted, the pin also accepts the four strobes of the neighbouring channel, which gives eight events per pin per cycle. Compare codes share the same code space but have no effect on the drive state.

The drive state is held as a four-state machine: `S_OFF_LO`, `S_OFF_HI`, `S_ON_LO` and `S_ON_HI`. The state name gives the enable and the data level. A transition between any two states is named by the code that causes it:

- `DRV_LO` and `DRV_HI` move between the data halves and keep the enable half.
- `OFF` moves an `S_ON_*` state to the matching `S_OFF_*` state.
- `PRIOR` moves an `S_OFF_*` state to the matching `S_ON_*` state.
- `UP` moves any state to `S_ON_HI`, and `DOWN` moves any state to `S_ON_LO`.
- A cycle with no effective strobe is the `hold` transition.

Top module: `pin_drive_formatter`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the outputs are drv_en=0, drv_data=0 and load_en=1 (state S_OFF_LO).
- R2: load_en is always the complement of drv_en.
- R3: Code 4'd1 (DRV_LO) clears the data and code 4'd2 (DRV_HI) sets the data. Both leave the enable unchanged.
- R4: Code 4'd3 (OFF) clears the enable, which turns the load on. The data is unchanged.
- R5: Code 4'd4 (UP) sets both the enable and the data. Code 4'd5 (DOWN) sets the enable and clears the data. Both turn the load off.
- R6: Code 4'd6 (PRIOR) sets the enable and leaves the data unchanged.
- R7: Code 4'd0 (no action) and the compare codes 4'd7 to 4'd15 do not change the drive state.
- R8: Strobes that arrive in the same cycle take effect in ascending event index. Own events are indices 0 to 3, at bit i of own_strobe and code bits [4i+3:4i]. Where they conflict, the higher index wins.
- R9: With pair_mode=1, the neighbour strobes act as event indices 4 to 7 and take effect after all own events. With pair_mode=0, the neighbour strobes and codes have no effect.
- R10: A strobe takes effect on the outputs one clock after it is presented. A cycle with no effective strobe holds the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | Accept the neighbour channel's events as indices 4..7 |
| own_strobe | input | 4 | Own event strobes, one bit per event |
| own_code | input | 16 | Own event codes, 4 bits per event |
| nbr_strobe | input | 4 | Neighbour channel event strobes |
| nbr_code | input | 16 | Neighbour channel event codes |
| drv_data | output | 1 | Drive data level |
| drv_en | output | 1 | Drive enable level |
| load_en | output | 1 | Termination load enable (complement of drv_en) |

## Verification
A wrong internal state shows at the ports one clock after the strobe that caused it, as a drive data or enable level that differs from the level the sequence of codes implies. The error then persists until a code overwrites that half of the state. For this reason, data-preserving codes (OFF, PRIOR) following data-setting codes are the sharpest probes. Ordering faults show only when strobes conflict within one cycle, including conflicts across the own/neighbour boundary in pair mode.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE   = 4'd0,
        EV_DRV_LO = 4'd1,
        EV_DRV_HI = 4'd2,
        EV_OFF    = 4'd3,
        EV_UP     = 4'd4,
        EV_DOWN   = 4'd5,
        EV_PRIOR  = 4'd6,
        EV_CMP_LO = 4'd7,
        EV_CMP_HI = 4'd8,
        EV_CMP_X  = 4'd9,
        EV_CMP_MID = 4'd10,
        EV_CMP_VAL = 4'd11,
        EV_WIN_LO = 4'd12,
        EV_WIN_HI = 4'd13,
        EV_WIN_MID = 4'd14,
        EV_WIN_VAL = 4'd15
    } ev_code_t;

    typedef struct packed {
        logic set_d;
        logic clr_d;
        logic set_e;
        logic clr_e;
    } ev_act_t;

    // state encoding is {enable, data}
    typedef enum logic [1:0] {
        S_OFF_LO = 2'b00,
        S_OFF_HI = 2'b01,
        S_ON_LO  = 2'b10,
        S_ON_HI  = 2'b11
    } drv_state_t;

endpackage

// File: rtl/pdf_event_decode.sv
module pdf_event_decode
    import pdf_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output ev_act_t           act
);
    always_comb begin
        act = '0;
        unique case (ev_code_t'(code))
            EV_DRV_LO: act.clr_d = 1'b1;
            EV_DRV_HI: act.set_d = 1'b1;
            EV_OFF:    act.clr_e = 1'b1;
            EV_UP:     begin act.set_e = 1'b1; act.set_d = 1'b1; end
            EV_DOWN:   begin act.set_e = 1'b1; act.clr_d = 1'b1; end
            EV_PRIOR:  act.set_e = 1'b1;
            default:   act = '0;  // no action and compare codes
        endcase
    end
endmodule

// File: rtl/pdf_sequencer.sv
module pdf_sequencer
    import pdf_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [1:0]         cur,      // {enable, data}
    input  logic [NSLOT-1:0]   valid,
    input  ev_act_t            act [NSLOT],
    output logic [1:0]         nxt
);
    always_comb begin
        logic e;
        logic d;
        e = cur[1];
        d = cur[0];
        // ascending index: later slots overwrite earlier ones
        for (int i = 0; i < NSLOT; i++) begin
            if (valid[i]) begin
                if (act[i].set_d) d = 1'b1;
                if (act[i].clr_d) d = 1'b0;
                if (act[i].set_e) e = 1'b1;
                if (act[i].clr_e) e = 1'b0;
            end
        end
        nxt = {e, d};
    end
endmodule

// File: rtl/pin_drive_formatter.sv
module pin_drive_formatter
    import pdf_pkg::*;
#(
    parameter int EV_PER_CH = 4,
    parameter int CW        = CODE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pair_mode,
    input  logic [EV_PER_CH-1:0]    own_strobe,
    input  logic [EV_PER_CH*CW-1:0] own_code,
    input  logic [EV_PER_CH-1:0]    nbr_strobe,
    input  logic [EV_PER_CH*CW-1:0] nbr_code,
    output logic                    drv_data,
    output logic                    drv_en,
    output logic                    load_en
);
    localparam int NSLOT = 2 * EV_PER_CH;

    drv_state_t         state_q;
    drv_state_t         state_d;
    logic [NSLOT-1:0]   slot_valid;
    ev_act_t            slot_act [NSLOT];
    logic [1:0]         seq_nxt;

    assign slot_valid = {nbr_strobe & {EV_PER_CH{pair_mode}}, own_strobe};

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        if (g < EV_PER_CH) begin : g_own
            pdf_event_decode u_dec (
                .code (own_code[g*CW +: CW]),
                .act  (slot_act[g])
            );
        end else begin : g_nbr
            pdf_event_decode u_dec (
                .code (nbr_code[(g-EV_PER_CH)*CW +: CW]),
                .act  (slot_act[g])
            );
        end
    end

    pdf_sequencer #(.NSLOT(NSLOT)) u_seq (
        .cur   (state_q),
        .valid (slot_valid),
        .act   (slot_act),
        .nxt   (seq_nxt)
    );

    always_comb begin
        unique case (seq_nxt)
            2'b00:   state_d = S_OFF_LO;
            2'b01:   state_d = S_OFF_HI;
            2'b10:   state_d = S_ON_LO;
            default: state_d = S_ON_HI;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF_LO;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_OFF_LO: begin drv_en = 1'b0; drv_data = 1'b0; end
            S_OFF_HI: begin drv_en = 1'b0; drv_data = 1'b1; end
            S_ON_LO:  begin drv_en = 1'b1; drv_data = 1'b0; end
            default:  begin drv_en = 1'b1; drv_data = 1'b1; end
        endcase
        load_en = ~drv_en;
    end

    logic idle_cycle;
    logic solo_own0;
    assign idle_cycle = (own_strobe == '0) && (!pair_mode || nbr_strobe == '0);
    assign solo_own0  = (own_strobe == 'd1) && (!pair_mode || nbr_strobe == '0);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!drv_en && !drv_data && load_en));

    p_load_compl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en != drv_en);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cycle |=> ($stable(drv_en) && $stable(drv_data)));

    p_up_solo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_own0 && own_code[CW-1:0] == EV_UP) |=> (drv_en && drv_data));

    p_off_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_own0 && own_code[CW-1:0] == EV_OFF) |=> (!drv_en && $stable(drv_data)));

    p_prior_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (solo_own0 && own_code[CW-1:0] == EV_PRIOR) |=> (drv_en && $stable(drv_data)));

endmodule

// File: tb/pin_drive_formatter_tb.sv
module pin_drive_formatter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_mode = 1'b0;
    logic [3:0]  own_strobe = '0;
    logic [15:0] own_code = '0;
    logic [3:0]  nbr_strobe = '0;
    logic [15:0] nbr_code = '0;
    logic        drv_data, drv_en, load_en;

    int checks = 0;
    int fails  = 0;
    logic [1:0] exp_ed = 2'b00;   // {enable, data}

    always #4 clk = ~clk;   // 125 MHz

    pin_drive_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .pair_mode(pair_mode),
        .own_strobe(own_strobe), .own_code(own_code),
        .nbr_strobe(nbr_strobe), .nbr_code(nbr_code),
        .drv_data(drv_data), .drv_en(drv_en), .load_en(load_en)
    );

    function automatic logic [1:0] apply_code(logic [1:0] ed, logic [3:0] c);
        logic e = ed[1];
        logic d = ed[0];
        case (c)
            4'd1: d = 1'b0;
            4'd2: d = 1'b1;
            4'd3: e = 1'b0;
            4'd4: begin e = 1'b1; d = 1'b1; end
            4'd5: begin e = 1'b1; d = 1'b0; end
            4'd6: e = 1'b1;
            default: ;
        endcase
        return {e, d};
    endfunction

    function automatic logic [1:0] model(logic [1:0] ed, logic pm,
                                         logic [3:0] os, logic [15:0] oc,
                                         logic [3:0] ns, logic [15:0] nc);
        logic [1:0] r = ed;
        for (int i = 0; i < 4; i++)
            if (os[i]) r = apply_code(r, oc[i*4 +: 4]);
        if (pm)
            for (int i = 0; i < 4; i++)
                if (ns[i]) r = apply_code(r, nc[i*4 +: 4]);
        return r;
    endfunction

    task automatic check_out(input string req);
        checks++;
        if ({drv_en, drv_data} !== exp_ed) begin
            fails++;
            $display("FAIL %s: en/data actual=%b expected=%b", req, {drv_en, drv_data}, exp_ed);
        end
        checks++;
        if (load_en !== ~exp_ed[1]) begin
            fails++;
            $display("FAIL R2 (%s): load_en actual=%b expected=%b", req, load_en, ~exp_ed[1]);
        end
    endtask

    // called at a negedge; result checked at the following negedge
    task automatic step(input logic pm, input logic [3:0] os, input logic [15:0] oc,
                        input logic [3:0] ns, input logic [15:0] nc, input string req);
        pair_mode = pm; own_strobe = os; own_code = oc; nbr_strobe = ns; nbr_code = nc;
        exp_ed = model(exp_ed, pm, os, oc, ns, nc);
        @(posedge clk);
        @(negedge clk);
        check_out(req);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (3) @(negedge clk);
        exp_ed = 2'b00;
        check_out("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_out("R1 after release");

        step(0, 4'b0001, 16'h0002, 0, 0, "R3 DRV_HI keeps enable off");
        step(0, 4'b0001, 16'h0001, 0, 0, "R3 DRV_LO");
        step(0, 4'b0010, 16'h0020, 0, 0, "R3 DRV_HI slot1");
        step(0, 4'b0001, 16'h0006, 0, 0, "R6 PRIOR keeps high");
        step(0, 4'b0100, 16'h0300, 0, 0, "R4 OFF keeps data");
        step(0, 4'b1000, 16'h5000, 0, 0, "R5 DOWN");
        step(0, 4'b0001, 16'h0004, 0, 0, "R5 UP");
        step(0, 4'b0000, 16'h0003, 0, 0, "R10 hold without strobe");
        for (int c = 7; c < 16; c++)
            step(0, 4'b1111, {4{4'(c)}}, 0, 0, "R7 compare codes ignored");
        step(0, 4'b0001, 16'h0000, 0, 0, "R7 no-action code");
        step(0, 4'b1001, 16'h3004, 0, 0, "R8 UP then OFF, OFF wins");
        step(0, 4'b1001, 16'h5004, 0, 0, "R8 higher index DOWN wins");
        step(0, 4'b0011, 16'h0012, 0, 0, "R8 DRV_HI then DRV_LO");
        step(0, 4'b0000, 0, 4'b0001, 16'h0003, "R9 neighbour ignored off pair");
        step(1, 4'b1000, 16'h4000, 4'b0001, 16'h0003, "R9 neighbour after own");
        step(1, 4'b0000, 0, 4'b0101, 16'h0206, "R9 neighbour slots ordered");

        for (int n = 0; n < 400; n++)
            step(1'($urandom), 4'($urandom), 16'($urandom), 4'($urandom),
                 16'($urandom), "R8 R9 random");

        rst_n = 1'b0;
        exp_ed = 2'b00;
        #1;
        check_out("R1 async reset");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule